// File: doc/BRIEF.md
# AXI Master Progress Monitor

This block sits beside one AXI4 master port and watches it without driving anything. On each direction it counts address handshakes (requests) and completion handshakes, and it keeps a running count of transactions still in flight. When a master stalls, these numbers show how many requests were issued, how many came back and on which side the traffic stopped.

Each direction also has a watchdog. On the write side it runs while a burst has had its final data beat accepted but its write response has not yet arrived. On the read side it runs while any read is in flight. If the watchdog reaches a programmable threshold, a sticky timeout flag is set. A completion that arrives while nothing is outstanding sets a sticky underflow flag. Software reads every value through a small register port. Writing the status address clears the counters, the flags, or both.

Top module: `axi_progress_mon`

## Requirements
- R1: The write request count (address 0) rises by one on every cycle with `aw_valid` and `aw_ready` both high. The write completion count (address 1) rises by one on every cycle with `b_valid` and `b_ready` both high.
- R2: The read request count (address 2) rises by one on every cycle with `ar_valid` and `ar_ready` both high. The read completion count (address 3) rises only on a beat where `r_valid`, `r_ready` and `r_last` are all high. Beats without `r_last` leave it unchanged.
- R3: The outstanding count per direction is read at address 4 (write) and address 5 (read). It rises by one on a request, falls by one on a completion, and stays unchanged when both occur in the same cycle.
- R4: A completion seen while that direction's outstanding count is zero sets the underflow flag: status bit 2 for write, bit 3 for read. The count does not go below zero. A request in the same cycle is still counted, so the outstanding count becomes 1.
- R5: The write watchdog runs only while at least one burst has had a beat with `w_valid`, `w_ready` and `w_last` high and is still without a response. It counts consecutive such cycles without a write completion. Status bit 0 is set after exactly T cycles following the accepting clock edge, where T is the write threshold at address 6. A completion at the T-th edge prevents the flag.
- R6: The read watchdog runs while the read outstanding count is nonzero. It sets status bit 1 after T cycles without a read completion, where T is the read threshold at address 7.
- R7: Thresholds are writable at addresses 6 and 7 and reset to the parameter `DEF_TMO`. A threshold of 0 disables that watchdog.
- R8: Every count saturates at all ones instead of wrapping.
- R9: Status flags are sticky. Writing address 8 with bit 1 set clears them. A flag event in the same cycle as that clear leaves the flag set.
- R10: Writing address 8 with bit 0 set zeroes all counts and both watchdogs. This clear takes precedence over a handshake in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aw_valid | input | 1 | Observed write address valid |
| aw_ready | input | 1 | Observed write address ready |
| w_valid | input | 1 | Observed write data valid |
| w_ready | input | 1 | Observed write data ready |
| w_last | input | 1 | Observed final write beat |
| b_valid | input | 1 | Observed write response valid |
| b_ready | input | 1 | Observed write response ready |
| ar_valid | input | 1 | Observed read address valid |
| ar_ready | input | 1 | Observed read address ready |
| r_valid | input | 1 | Observed read data valid |
| r_ready | input | 1 | Observed read data ready |
| r_last | input | 1 | Observed final read beat |
| cfg_addr | input | 4 | Register address |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | TMO_W | Register write data |
| cfg_rdata | output | 32 | Register read data, zero-extended |

## Verification
Two functions can fall in the same cycle on one direction: a request and a completion arriving together while nothing is outstanding. The bench provokes this by raising the read address and final read beat handshakes in a single cycle. It expects an outstanding count of 1, both counts at 1, and the read underflow flag set. Two further collisions are also provoked. A counter clear is written in the same cycle as a write address handshake, and the request must not survive. A flag clear is written in the same cycle as a stray write response, and the underflow flag must remain set. A patterned sweep over all channels is compared with counts the bench computes itself.

// File: rtl/apm_pkg.sv
package apm_pkg;
  localparam int CFG_AW = 4;
  localparam int RD_W   = 32;

  typedef enum logic [CFG_AW-1:0] {
    RA_WR_REQ = 4'd0,
    RA_WR_CPL = 4'd1,
    RA_RD_REQ = 4'd2,
    RA_RD_CPL = 4'd3,
    RA_WR_OUT = 4'd4,
    RA_RD_OUT = 4'd5,
    RA_WR_THR = 4'd6,
    RA_RD_THR = 4'd7,
    RA_STATUS = 4'd8
  } reg_addr_e;

  localparam int ST_WR_TO = 0;
  localparam int ST_RD_TO = 1;
  localparam int ST_WR_UF = 2;
  localparam int ST_RD_UF = 3;
  localparam int ST_W     = 4;
endpackage

// File: rtl/apm_sat_cnt.sv
module apm_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = '1;
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr)                            q_d = '0;
    else if (inc && !dec && q != MAXV)  q_d = q + 1'b1;
    else if (dec && !inc && q != '0)    q_d = q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/apm_dir_track.sv
module apm_dir_track #(
  parameter int CNT_W = 32,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             cpl,
  input  logic             arm,
  input  logic             clr_cnt,
  input  logic             clr_flg,
  input  logic [TMO_W-1:0] thr,
  output logic [CNT_W-1:0] req_q,
  output logic [CNT_W-1:0] cpl_q,
  output logic [CNT_W-1:0] out_q,
  output logic             to_q,
  output logic             uf_q
);
  localparam logic [TMO_W-1:0] WD_MAX = '1;

  logic [CNT_W-1:0] arm_q;
  logic             out_dec, arm_dec, uf_evt;
  logic [TMO_W-1:0] wd_q, wd_d, wd_inc;
  logic             run, fire, to_d, uf_d;

  assign out_dec = cpl && (out_q != '0);
  assign arm_dec = cpl && (arm_q != '0);
  assign uf_evt  = cpl && (out_q == '0);

  apm_sat_cnt #(.W(CNT_W)) u_req (.clk(clk), .rst_n(rst_n), .clr(clr_cnt),
    .inc(req), .dec(1'b0), .q(req_q));
  apm_sat_cnt #(.W(CNT_W)) u_cpl (.clk(clk), .rst_n(rst_n), .clr(clr_cnt),
    .inc(cpl), .dec(1'b0), .q(cpl_q));
  apm_sat_cnt #(.W(CNT_W)) u_out (.clk(clk), .rst_n(rst_n), .clr(clr_cnt),
    .inc(req), .dec(out_dec), .q(out_q));
  apm_sat_cnt #(.W(CNT_W)) u_arm (.clk(clk), .rst_n(rst_n), .clr(clr_cnt),
    .inc(arm), .dec(arm_dec), .q(arm_q));

  always_comb begin
    wd_inc = (wd_q == WD_MAX) ? wd_q : wd_q + 1'b1;
    run    = (arm_q != '0) && !cpl && !clr_cnt;
    wd_d   = run ? wd_inc : '0;
    fire   = run && (thr != '0) && (wd_inc == thr);
    to_d   = fire   || (to_q && !clr_flg);
    uf_d   = uf_evt || (uf_q && !clr_flg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q <= '0;
      to_q <= 1'b0;
      uf_q <= 1'b0;
    end else begin
      wd_q <= wd_d;
      to_q <= to_d;
      uf_q <= uf_d;
    end
  end
endmodule

// File: rtl/apm_regs.sv
module apm_regs
  import apm_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int TMO_W   = 16,
  parameter int DEF_TMO = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_we,
  input  logic [TMO_W-1:0]  cfg_wdata,
  input  logic [CNT_W-1:0]  wr_req_q,
  input  logic [CNT_W-1:0]  wr_cpl_q,
  input  logic [CNT_W-1:0]  rd_req_q,
  input  logic [CNT_W-1:0]  rd_cpl_q,
  input  logic [CNT_W-1:0]  wr_out_q,
  input  logic [CNT_W-1:0]  rd_out_q,
  input  logic [ST_W-1:0]   flags,
  output logic [RD_W-1:0]   cfg_rdata,
  output logic [TMO_W-1:0]  wr_thr,
  output logic [TMO_W-1:0]  rd_thr,
  output logic              clr_cnt,
  output logic              clr_flg
);
  logic [TMO_W-1:0] wr_thr_d, rd_thr_d;
  logic             st_we;

  assign st_we   = cfg_we && (cfg_addr == RA_STATUS);
  assign clr_cnt = st_we && cfg_wdata[0];
  assign clr_flg = st_we && cfg_wdata[1];

  always_comb begin
    wr_thr_d = wr_thr;
    rd_thr_d = rd_thr;
    if (cfg_we && cfg_addr == RA_WR_THR) wr_thr_d = cfg_wdata;
    if (cfg_we && cfg_addr == RA_RD_THR) rd_thr_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_thr <= TMO_W'(DEF_TMO);
      rd_thr <= TMO_W'(DEF_TMO);
    end else begin
      wr_thr <= wr_thr_d;
      rd_thr <= rd_thr_d;
    end
  end

  always_comb begin
    case (reg_addr_e'(cfg_addr))
      RA_WR_REQ: cfg_rdata = RD_W'(wr_req_q);
      RA_WR_CPL: cfg_rdata = RD_W'(wr_cpl_q);
      RA_RD_REQ: cfg_rdata = RD_W'(rd_req_q);
      RA_RD_CPL: cfg_rdata = RD_W'(rd_cpl_q);
      RA_WR_OUT: cfg_rdata = RD_W'(wr_out_q);
      RA_RD_OUT: cfg_rdata = RD_W'(rd_out_q);
      RA_WR_THR: cfg_rdata = RD_W'(wr_thr);
      RA_RD_THR: cfg_rdata = RD_W'(rd_thr);
      RA_STATUS: cfg_rdata = RD_W'(flags);
      default:   cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/axi_progress_mon.sv
module axi_progress_mon
  import apm_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int TMO_W   = 16,
  parameter int DEF_TMO = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic              w_valid,
  input  logic              w_ready,
  input  logic              w_last,
  input  logic              b_valid,
  input  logic              b_ready,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic              r_last,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_we,
  input  logic [TMO_W-1:0]  cfg_wdata,
  output logic [RD_W-1:0]   cfg_rdata
);
  logic [CNT_W-1:0] wr_req_q, wr_cpl_q, wr_out_q;
  logic [CNT_W-1:0] rd_req_q, rd_cpl_q, rd_out_q;
  logic [TMO_W-1:0] wr_thr, rd_thr;
  logic             clr_cnt, clr_flg;
  logic             wr_to, rd_to, wr_uf, rd_uf;
  logic [ST_W-1:0]  flags;
  logic             aw_hs, w_end, b_hs, ar_hs, r_end;

  assign aw_hs = aw_valid && aw_ready;
  assign w_end = w_valid && w_ready && w_last;
  assign b_hs  = b_valid && b_ready;
  assign ar_hs = ar_valid && ar_ready;
  assign r_end = r_valid && r_ready && r_last;

  always_comb begin
    flags           = '0;
    flags[ST_WR_TO] = wr_to;
    flags[ST_RD_TO] = rd_to;
    flags[ST_WR_UF] = wr_uf;
    flags[ST_RD_UF] = rd_uf;
  end

  apm_dir_track #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .req(aw_hs), .cpl(b_hs), .arm(w_end),
    .clr_cnt(clr_cnt), .clr_flg(clr_flg), .thr(wr_thr),
    .req_q(wr_req_q), .cpl_q(wr_cpl_q), .out_q(wr_out_q),
    .to_q(wr_to), .uf_q(wr_uf));

  apm_dir_track #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .req(ar_hs), .cpl(r_end), .arm(ar_hs),
    .clr_cnt(clr_cnt), .clr_flg(clr_flg), .thr(rd_thr),
    .req_q(rd_req_q), .cpl_q(rd_cpl_q), .out_q(rd_out_q),
    .to_q(rd_to), .uf_q(rd_uf));

  apm_regs #(.CNT_W(CNT_W), .TMO_W(TMO_W), .DEF_TMO(DEF_TMO)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .wr_req_q(wr_req_q), .wr_cpl_q(wr_cpl_q),
    .rd_req_q(rd_req_q), .rd_cpl_q(rd_cpl_q), .wr_out_q(wr_out_q),
    .rd_out_q(rd_out_q), .flags(flags), .cfg_rdata(cfg_rdata),
    .wr_thr(wr_thr), .rd_thr(rd_thr), .clr_cnt(clr_cnt), .clr_flg(clr_flg));
endmodule

// File: rtl/apm_chk.sv
module apm_chk #(
  parameter int CNT_W = 32,
  parameter int TMO_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             aw_valid,
  input logic             aw_ready,
  input logic             b_valid,
  input logic             b_ready,
  input logic             r_valid,
  input logic             r_ready,
  input logic             r_last,
  input logic [CNT_W-1:0] wr_req_q,
  input logic [CNT_W-1:0] rd_req_q,
  input logic [CNT_W-1:0] rd_cpl_q,
  input logic [CNT_W-1:0] wr_out_q,
  input logic [TMO_W-1:0] rd_thr,
  input logic [3:0]       flags,
  input logic             clr_cnt,
  input logic             clr_flg
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_wr_req_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && aw_ready && !clr_cnt && wr_req_q != CMAX)
      |=> wr_req_q == $past(wr_req_q) + 1'b1);

  p_rd_cpl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_cnt && !(r_valid && r_ready && r_last)) |=> rd_cpl_q == $past(rd_cpl_q));

  p_wr_out_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && aw_ready && !(b_valid && b_ready) && !clr_cnt && wr_out_q != CMAX)
      |=> wr_out_q == $past(wr_out_q) + 1'b1);

  p_wr_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && b_ready && wr_out_q == '0) |=> flags[2]);

  p_rd_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_thr == '0 && !flags[1]) |=> !flags[1]);

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_q == CMAX && !clr_cnt) |=> wr_req_q == CMAX);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !clr_flg) |=> flags[0]);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt |=> (wr_req_q == '0 && rd_req_q == '0));
endmodule

bind axi_progress_mon apm_chk #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .aw_valid(aw_valid), .aw_ready(aw_ready),
  .b_valid(b_valid), .b_ready(b_ready), .r_valid(r_valid), .r_ready(r_ready),
  .r_last(r_last), .wr_req_q(wr_req_q), .rd_req_q(rd_req_q),
  .rd_cpl_q(rd_cpl_q), .wr_out_q(wr_out_q), .rd_thr(rd_thr), .flags(flags),
  .clr_cnt(clr_cnt), .clr_flg(clr_flg));

// File: tb/axi_progress_mon_tb.sv
module axi_progress_mon_tb;
  localparam int CNT_W = 6;
  localparam int TMO_W = 8;
  localparam int DEF   = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready;
  logic ar_valid, ar_ready, r_valid, r_ready, r_last;
  logic [3:0] cfg_addr;
  logic cfg_we;
  logic [TMO_W-1:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  axi_progress_mon #(.CNT_W(CNT_W), .TMO_W(TMO_W), .DEF_TMO(DEF)) u_dut (
    .clk(clk), .rst_n(rst_n), .aw_valid(aw_valid), .aw_ready(aw_ready),
    .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready), .ar_valid(ar_valid),
    .ar_ready(ar_ready), .r_valid(r_valid), .r_ready(r_ready),
    .r_last(r_last), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
    cfg_addr = a;
    #1;
    checks++;
    if (cfg_rdata !== exp) begin
      fails++;
      $display("FAIL %s: addr %0d got %0d expected %0d", tag, a, cfg_rdata, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [TMO_W-1:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic zero_bus();
    aw_valid = 0; aw_ready = 0; w_valid = 0; w_ready = 0; w_last = 0;
    b_valid = 0; b_ready = 0; ar_valid = 0; ar_ready = 0;
    r_valid = 0; r_ready = 0; r_last = 0;
  endtask

  task automatic pulse_aw(); aw_valid = 1; aw_ready = 1; tick(); aw_valid = 0; aw_ready = 0; endtask
  task automatic pulse_w();  w_valid = 1; w_ready = 1; w_last = 1; tick(); w_valid = 0; w_ready = 0; w_last = 0; endtask
  task automatic pulse_b();  b_valid = 1; b_ready = 1; tick(); b_valid = 0; b_ready = 0; endtask
  task automatic pulse_ar(); ar_valid = 1; ar_ready = 1; tick(); ar_valid = 0; ar_ready = 0; endtask
  task automatic pulse_r(input logic last);
    r_valid = 1; r_ready = 1; r_last = last; tick(); r_valid = 0; r_ready = 0; r_last = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int e_wreq, e_wcpl, e_rreq, e_rcpl, e_wout, e_rout, e_st;
    zero_bus();
    cfg_addr = 0; cfg_we = 0; cfg_wdata = 0;
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(1);

    // reset state (R1, R3, R7)
    for (int a = 0; a < 6; a++) chk_reg("R1 reset count", 4'(a), 0);
    chk_reg("R7 reset write threshold", 6, DEF);
    chk_reg("R7 reset read threshold", 7, DEF);
    chk_reg("R9 reset status", 8, 0);

    // patterned sweep, watchdogs off (R1 R2 R3 R4)
    wr(6, 0); wr(7, 0);
    e_wreq = 0; e_wcpl = 0; e_rreq = 0; e_rcpl = 0; e_wout = 0; e_rout = 0; e_st = 0;
    for (int i = 0; i < 48; i++) begin
      logic awh, bh, arh, rh;
      aw_valid = (i % 3 != 2); aw_ready = (i % 2 == 0);
      b_valid  = (i % 4 == 1); b_ready  = (i % 5 != 0);
      ar_valid = (i % 2 == 1); ar_ready = (i % 3 != 0);
      r_valid  = (i % 3 == 0); r_ready  = (i % 4 != 3); r_last = (i % 2 == 0);
      awh = aw_valid & aw_ready; bh = b_valid & b_ready;
      arh = ar_valid & ar_ready; rh = r_valid & r_ready & r_last;
      e_wreq += int'(awh); e_wcpl += int'(bh);
      e_rreq += int'(arh); e_rcpl += int'(rh);
      if (bh && e_wout == 0) e_st |= 4;
      if (rh && e_rout == 0) e_st |= 8;
      e_wout = e_wout + int'(awh) - int'(bh && e_wout != 0);
      e_rout = e_rout + int'(arh) - int'(rh && e_rout != 0);
      tick();
    end
    zero_bus();
    chk_reg("R1 sweep write requests", 0, e_wreq);
    chk_reg("R1 sweep write completions", 1, e_wcpl);
    chk_reg("R2 sweep read requests", 2, e_rreq);
    chk_reg("R2 sweep read completions", 3, e_rcpl);
    chk_reg("R3 sweep write outstanding", 4, e_wout);
    chk_reg("R3 sweep read outstanding", 5, e_rout);
    chk_reg("R4 sweep underflow flags", 8, e_st);

    wr(8, 3);
    chk_reg("R10 counts cleared", 0, 0);
    chk_reg("R10 outstanding cleared", 5, 0);
    chk_reg("R9 flags cleared", 8, 0);

    // read completion needs final beat (R2)
    pulse_ar();
    pulse_r(0); pulse_r(0); pulse_r(0);
    chk_reg("R2 non-final beats ignored", 3, 0);
    chk_reg("R3 read still outstanding", 5, 1);
    pulse_r(1);
    chk_reg("R2 final beat counted", 3, 1);
    chk_reg("R3 read drained", 5, 0);

    // saturation (R8)
    aw_valid = 1; aw_ready = 1;
    idle(70);
    aw_valid = 0; aw_ready = 0;
    chk_reg("R8 request count saturates", 0, 63);
    chk_reg("R8 outstanding saturates", 4, 63);
    wr(8, 3);

    // write watchdog (R5, R9)
    wr(6, 5);
    pulse_aw();
    idle(10);
    chk_reg("R5 no timeout before final data beat", 8, 0);
    pulse_w();
    idle(4);
    chk_reg("R5 no timeout one cycle early", 8, 0);
    idle(1);
    chk_reg("R5 write timeout at threshold", 8, 1);
    idle(3);
    chk_reg("R9 timeout sticky", 8, 1);
    pulse_b();
    chk_reg("R9 sticky after response", 8, 1);
    wr(8, 2);
    chk_reg("R9 flag clear", 8, 0);

    // completion exactly at threshold edge (R5)
    pulse_aw();
    pulse_w();
    idle(4);
    pulse_b();
    idle(6);
    chk_reg("R5 just-in-time response avoids flag", 8, 0);

    // read watchdog (R6)
    wr(7, 3);
    pulse_ar();
    idle(2);
    chk_reg("R6 read no timeout early", 8, 0);
    idle(1);
    chk_reg("R6 read timeout", 8, 2);
    pulse_r(1);
    wr(8, 2);

    // threshold zero disables (R7)
    wr(7, 0);
    chk_reg("R7 threshold readback", 7, 0);
    pulse_ar();
    idle(20);
    chk_reg("R7 disabled watchdog silent", 8, 0);
    pulse_r(1);

    // request and completion together at zero outstanding (R4)
    wr(8, 3);
    ar_valid = 1; ar_ready = 1; r_valid = 1; r_ready = 1; r_last = 1;
    tick();
    zero_bus();
    chk_reg("R4 same-cycle read requests", 2, 1);
    chk_reg("R4 same-cycle read completions", 3, 1);
    chk_reg("R4 same-cycle outstanding", 5, 1);
    chk_reg("R4 read underflow flag", 8, 8);
    pulse_r(1);
    chk_reg("R3 outstanding back to zero", 5, 0);
    wr(8, 2);

    // clear versus handshake (R10)
    aw_valid = 1; aw_ready = 1;
    wr(8, 1);
    aw_valid = 0; aw_ready = 0;
    chk_reg("R10 clear beats same-cycle request", 0, 0);

    // flag event versus flag clear (R9)
    b_valid = 1; b_ready = 1;
    wr(8, 2);
    b_valid = 0; b_ready = 0;
    chk_reg("R9 event survives same-cycle clear", 8, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule